// File: doc/BRIEF.md
# Generic Command Packet Serializer

This block sits on the host side of a serial display link and turns command packets into a byte stream. Software loads payload words into one queue and header words into a second queue. Each header word produces one packet. The header word alone decides the framing. A short packet carries at most two data bytes inside the header. A long packet takes the byte count from the header and draws that many payload bytes from the payload queue.

Every packet starts with four header bytes: the identifier byte, the two data-field bytes, and a 6-bit Hamming ECC byte. A long packet then sends its payload bytes, followed by a 16-bit CRC. Software paces itself with the full and empty flags. A command is complete once both empty flags are high. Writes to a full queue are dropped and raise a sticky overflow flag.

Top module: `gcmd_pkt_engine`

## Requirements
- R1: A header word is laid out as data type in bits 5:0, virtual channel in bits 7:6 and a 16-bit data field in bits 23:8; bits 31:24 are ignored. The packet opens with header bits 7:0, then bits 15:8, then bits 23:16, then the ECC byte.
- R2: Bit i (i = 0..5) of the ECC byte is the parity of the 24 header bits selected by mask i: 0xF12CB7, 0xF2555B, 0x749A6D, 0xB8E38E, 0xDF03F0, 0xEFFC00. ECC bits 7:6 are zero.
- R3: Data-type bit 3 picks the framing. When it is clear (types 0x05 and 0x15), the packet is exactly the four header bytes, and tx_last is high on the fourth byte. tx_last is never high without tx_valid.
- R4: When data-type bit 3 is set (type 0x39), the data field is a byte count N. Exactly N payload bytes follow the header. They are taken from the payload words low byte first. The unused upper bytes of a final partial word are discarded, so the next packet starts at a fresh word.
- R5: A long packet ends with a CRC over its payload bytes only. The polynomial is x^16+x^12+x^5+1 with seed 0xFFFF, bytes are fed LSB first, and there is no final inversion. The CRC is sent low byte first and tx_last is high on its second byte. With N = 0 the CRC bytes are 0xFF 0xFF.
- R6: While a long packet needs a payload byte and the payload queue is empty, tx_valid stays low. Transmission resumes when words arrive, and no word beyond the declared count is consumed.
- R7: Each queue holds HDR_DEPTH / PLD_DEPTH words (16 by default). Its full flag is high at that fill level. A write while full is dropped and sets that queue's overflow flag, which stays high until reset.
- R8: hdr_empty_o and pld_empty_o are high only when their queue is empty and no packet is in flight. When both are high, no further byte of the last packet remains to be sent.
- R9: After reset both empty flags are high, both full flags and both overflow flags are low, and tx_valid_o is low.
- R10: Queued headers are sent in write order. Packets are separated by at least one cycle with tx_valid_o low after each tx_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_wr_i | input | 1 | Push hdr_wdata_i into the header queue |
| hdr_wdata_i | input | 32 | Header word |
| pld_wr_i | input | 1 | Push pld_wdata_i into the payload queue |
| pld_wdata_i | input | 32 | Payload word, first byte in bits 7:0 |
| hdr_full_o | output | 1 | Header queue full |
| hdr_empty_o | output | 1 | Header queue empty and engine idle |
| pld_full_o | output | 1 | Payload queue full |
| pld_empty_o | output | 1 | Payload queue empty and engine idle |
| hdr_ovf_o | output | 1 | Sticky: a header write was dropped |
| pld_ovf_o | output | 1 | Sticky: a payload write was dropped |
| tx_valid_o | output | 1 | tx_byte_o carries a packet byte this cycle |
| tx_byte_o | output | 8 | Serialized packet byte |
| tx_last_o | output | 1 | Final byte of the current packet |

## Verification
The bench builds the block with its default depth of 16 for both queues. At that depth, overfilling either queue takes only seventeen writes. The header queue is filled completely behind a long packet that is starved of payload, which makes the full flag, the dropped write and the sticky flag reachable in one short scenario. Byte counts of 0, 3, 5, 8 and 64 cover empty, partial-word, exact-word and whole-queue payloads, so the CRC seed and the discarding of padding are both observed at the stream.

// File: rtl/gcmd_pkg.sv
package gcmd_pkg;
   localparam int WORD_W   = 32;
   localparam int BYTE_W   = 8;
   localparam int LONG_BIT = 3;
   localparam logic [15:0] CRC_SEED = 16'hFFFF;
   localparam logic [15:0] CRC_POLY_REFL = 16'h8408;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_PLD  = 2'd2,
      ST_CRC  = 2'd3
   } eng_state_t;

   function automatic logic [5:0] hdr_ecc(input logic [23:0] d);
      logic [5:0] p;
      p[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
      p[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
      p[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
      p[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
      p[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
      p[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
      return p;
   endfunction

   function automatic logic [15:0] crc_byte(input logic [15:0] c_in, input logic [7:0] b);
      logic [15:0] c;
      c = c_in ^ {8'h00, b};
      for (int i = 0; i < 8; i++) begin
         c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
      end
      return c;
   endfunction
endpackage

// File: rtl/gcmd_fifo.sv
module gcmd_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic             rd_i,
   output logic [WIDTH-1:0] rdata_o,
   output logic             full_o,
   output logic             empty_o,
   output logic             ovf_o
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [CW-1:0]    cnt_q;
   logic             wr_ok, rd_ok;

   assign full_o  = (cnt_q == FULL_CNT);
   assign empty_o = (cnt_q == '0);
   assign wr_ok   = wr_i & ~full_o;
   assign rd_ok   = rd_i & ~empty_o;
   assign rdata_o = mem_q[rp_q];

   always_ff @(posedge clk) begin
      if (wr_ok) mem_q[wp_q] <= wdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
         ovf_o <= 1'b0;
      end else begin
         if (wr_ok) wp_q <= wp_q + 1'b1;
         if (rd_ok) rp_q <= rp_q + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (wr_i && full_o) ovf_o <= 1'b1;
      end
   end
endmodule

// File: rtl/gcmd_serializer.sv
module gcmd_serializer
   import gcmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_empty_i,
   input  logic [WORD_W-1:0] hdr_word_i,
   output logic              hdr_pop_o,
   input  logic              pld_empty_i,
   input  logic [WORD_W-1:0] pld_word_i,
   output logic              pld_pop_o,
   output logic              busy_o,
   output logic              tx_valid_o,
   output logic [BYTE_W-1:0] tx_byte_o,
   output logic              tx_last_o
);
   eng_state_t  st_q;
   logic [23:0] hdr_q;
   logic [1:0]  idx_q;
   logic [1:0]  bsel_q;
   logic [15:0] rem_q;
   logic [15:0] crc_q;
   logic        is_long;
   logic [7:0]  hdr_byte;
   logic [7:0]  pld_byte;

   assign is_long  = hdr_q[LONG_BIT];
   assign busy_o   = (st_q != ST_IDLE);
   assign pld_byte = pld_word_i[8*bsel_q +: 8];

   always_comb begin
      case (idx_q)
         2'd0:    hdr_byte = hdr_q[7:0];
         2'd1:    hdr_byte = hdr_q[15:8];
         2'd2:    hdr_byte = hdr_q[23:16];
         default: hdr_byte = {2'b00, hdr_ecc(hdr_q)};
      endcase
   end

   assign hdr_pop_o = (st_q == ST_IDLE) && !hdr_empty_i;
   assign pld_pop_o = (st_q == ST_PLD) && !pld_empty_i &&
                      ((bsel_q == 2'd3) || (rem_q == 16'd1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         hdr_q      <= '0;
         idx_q      <= '0;
         bsel_q     <= '0;
         rem_q      <= '0;
         crc_q      <= CRC_SEED;
         tx_valid_o <= 1'b0;
         tx_byte_o  <= '0;
         tx_last_o  <= 1'b0;
      end else begin
         tx_valid_o <= 1'b0;
         tx_last_o  <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (!hdr_empty_i) begin
                  hdr_q <= hdr_word_i[23:0];
                  idx_q <= '0;
                  st_q  <= ST_HDR;
               end
            end
            ST_HDR: begin
               tx_valid_o <= 1'b1;
               tx_byte_o  <= hdr_byte;
               idx_q      <= idx_q + 1'b1;
               if (idx_q == 2'd3) begin
                  crc_q  <= CRC_SEED;
                  bsel_q <= '0;
                  rem_q  <= hdr_q[23:8];
                  idx_q  <= '0;
                  if (!is_long) begin
                     tx_last_o <= 1'b1;
                     st_q      <= ST_IDLE;
                  end else if (hdr_q[23:8] == 16'd0) begin
                     st_q <= ST_CRC;
                  end else begin
                     st_q <= ST_PLD;
                  end
               end
            end
            ST_PLD: begin
               if (!pld_empty_i) begin
                  tx_valid_o <= 1'b1;
                  tx_byte_o  <= pld_byte;
                  crc_q      <= crc_byte(crc_q, pld_byte);
                  rem_q      <= rem_q - 1'b1;
                  bsel_q     <= pld_pop_o ? 2'd0 : bsel_q + 1'b1;
                  if (rem_q == 16'd1) st_q <= ST_CRC;
               end
            end
            default: begin
               tx_valid_o <= 1'b1;
               idx_q      <= idx_q + 1'b1;
               if (idx_q == 2'd0) begin
                  tx_byte_o <= crc_q[7:0];
               end else begin
                  tx_byte_o <= crc_q[15:8];
                  tx_last_o <= 1'b1;
                  idx_q     <= '0;
                  st_q      <= ST_IDLE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/gcmd_pkt_engine.sv
module gcmd_pkt_engine
   import gcmd_pkg::*;
#(
   parameter int HDR_DEPTH = 16,
   parameter int PLD_DEPTH = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hdr_wr_i,
   input  logic [31:0] hdr_wdata_i,
   input  logic        pld_wr_i,
   input  logic [31:0] pld_wdata_i,
   output logic        hdr_full_o,
   output logic        hdr_empty_o,
   output logic        pld_full_o,
   output logic        pld_empty_o,
   output logic        hdr_ovf_o,
   output logic        pld_ovf_o,
   output logic        tx_valid_o,
   output logic [7:0]  tx_byte_o,
   output logic        tx_last_o
);
   generate
      if (HDR_DEPTH < 2 || (HDR_DEPTH & (HDR_DEPTH - 1)) != 0) begin : g_bad_hdr_depth
         $error("HDR_DEPTH must be a power of two, at least 2");
      end
      if (PLD_DEPTH < 2 || (PLD_DEPTH & (PLD_DEPTH - 1)) != 0) begin : g_bad_pld_depth
         $error("PLD_DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] hdr_rd, pld_rd;
   logic              hdr_pop, pld_pop;
   logic              hdr_q_empty, pld_q_empty;
   logic              busy;

   gcmd_fifo #(.WIDTH(WORD_W), .DEPTH(HDR_DEPTH)) u_hdr_q (
      .clk(clk), .rst_n(rst_n),
      .wr_i(hdr_wr_i), .wdata_i(hdr_wdata_i),
      .rd_i(hdr_pop), .rdata_o(hdr_rd),
      .full_o(hdr_full_o), .empty_o(hdr_q_empty), .ovf_o(hdr_ovf_o)
   );

   gcmd_fifo #(.WIDTH(WORD_W), .DEPTH(PLD_DEPTH)) u_pld_q (
      .clk(clk), .rst_n(rst_n),
      .wr_i(pld_wr_i), .wdata_i(pld_wdata_i),
      .rd_i(pld_pop), .rdata_o(pld_rd),
      .full_o(pld_full_o), .empty_o(pld_q_empty), .ovf_o(pld_ovf_o)
   );

   gcmd_serializer u_ser (
      .clk(clk), .rst_n(rst_n),
      .hdr_empty_i(hdr_q_empty), .hdr_word_i(hdr_rd), .hdr_pop_o(hdr_pop),
      .pld_empty_i(pld_q_empty), .pld_word_i(pld_rd), .pld_pop_o(pld_pop),
      .busy_o(busy),
      .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o), .tx_last_o(tx_last_o)
   );

   assign hdr_empty_o = hdr_q_empty & ~busy;
   assign pld_empty_o = pld_q_empty & ~busy;
endmodule

// File: rtl/gcmd_pkt_engine_chk.sv
module gcmd_pkt_engine_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        hdr_wr_i,
   input logic [31:0] hdr_wdata_i,
   input logic        pld_wr_i,
   input logic [31:0] pld_wdata_i,
   input logic        hdr_full_o,
   input logic        hdr_empty_o,
   input logic        pld_full_o,
   input logic        pld_empty_o,
   input logic        hdr_ovf_o,
   input logic        pld_ovf_o,
   input logic        tx_valid_o,
   input logic [7:0]  tx_byte_o,
   input logic        tx_last_o
);
   AST_HDR_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_wr_i && hdr_full_o |=> hdr_ovf_o); // R7
   AST_HDR_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_ovf_o |=> hdr_ovf_o); // R7
   AST_PLD_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      pld_wr_i && pld_full_o |=> pld_ovf_o); // R7
   AST_PLD_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pld_ovf_o |=> pld_ovf_o); // R7
   AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last_o |-> tx_valid_o); // R3
   AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last_o |=> !tx_valid_o); // R10
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_empty_o && pld_empty_o |-> !tx_valid_o || tx_last_o); // R8
endmodule

bind gcmd_pkt_engine gcmd_pkt_engine_chk u_chk (.*);

// File: tb/gcmd_pkt_engine_test.sv
module gcmd_pkt_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   localparam logic [31:0] VEC_HDR [NVEC] = '{
      32'h0000_1105,   // short, one byte
      32'h0033_2255,   // short with parameter, vc1
      32'h0000_05B9,   // long, 5 bytes, vc2
      32'h0000_00F9,   // long, 0 bytes, vc3
      32'h0000_0339,   // long, 3 bytes
      32'h0000_0879    // long, 8 bytes, vc1
   };
   localparam logic [23:0] ECC_MASK [6] = '{
      24'hF12CB7, 24'hF2555B, 24'h749A6D, 24'hB8E38E, 24'hDF03F0, 24'hEFFC00
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hdr_wr_i = 1'b0;
   logic [31:0] hdr_wdata_i = '0;
   logic        pld_wr_i = 1'b0;
   logic [31:0] pld_wdata_i = '0;
   logic        hdr_full_o, hdr_empty_o, pld_full_o, pld_empty_o;
   logic        hdr_ovf_o, pld_ovf_o, tx_valid_o, tx_last_o;
   logic [7:0]  tx_byte_o;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   int ncap = 0;
   int ne = 0;
   logic [7:0] cap_b [1024];
   logic       cap_l [1024];
   logic [7:0] exp_b [1024];
   logic       exp_l [1024];

   gcmd_pkt_engine uut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      cycles++;
      if (rst_n && tx_valid_o && ncap < 1024) begin
         cap_b[ncap] = tx_byte_o;
         cap_l[ncap] = tx_last_o;
         ncap++;
      end
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cycles);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   function automatic logic [31:0] pword(int v, int k);
      return 32'h1020_3040 * (v + 1) + 32'h0101_0101 * k + 32'h0B00_0000 * k;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic add_exp(logic [31:0] hdr, int v);
      logic [15:0] c;
      logic [7:0]  b;
      logic [7:0]  e;
      int n;
      e = 8'h00;
      for (int i = 0; i < 6; i++) e[i] = ^(hdr[23:0] & ECC_MASK[i]);
      exp_b[ne] = hdr[7:0];   exp_l[ne] = 1'b0; ne++;
      exp_b[ne] = hdr[15:8];  exp_l[ne] = 1'b0; ne++;
      exp_b[ne] = hdr[23:16]; exp_l[ne] = 1'b0; ne++;
      exp_b[ne] = e;          exp_l[ne] = !hdr[3]; ne++;
      if (hdr[3]) begin
         n = int'(hdr[23:8]);
         c = 16'hFFFF;
         for (int j = 0; j < n; j++) begin
            b = 8'(pword(v, j / 4) >> (8 * (j % 4)));
            exp_b[ne] = b; exp_l[ne] = 1'b0; ne++;
            for (int k = 0; k < 8; k++) begin
               logic fb;
               fb = c[0] ^ b[k];
               c = c >> 1;
               if (fb) c = c ^ 16'h8408;
            end
         end
         exp_b[ne] = c[7:0];  exp_l[ne] = 1'b0; ne++;
         exp_b[ne] = c[15:8]; exp_l[ne] = 1'b1; ne++;
      end
   endtask

   task automatic cmp_stream(string req, int base);
      int bad;
      bad = 0;
      checks++;
      if (ncap - base != ne) begin
         bad = 1;
         $display("FAIL %s: actual %0d bytes expected %0d bytes", req, ncap - base, ne);
      end else begin
         for (int i = 0; i < ne; i++) begin
            if (cap_b[base+i] !== exp_b[i] || cap_l[base+i] !== exp_l[i]) begin
               if (bad == 0)
                  $display("FAIL %s: byte %0d actual %h/last %b expected %h/last %b",
                           req, i, cap_b[base+i], cap_l[base+i], exp_b[i], exp_l[i]);
               bad = 1;
            end
         end
      end
      if (bad != 0) fails++;
      ne = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      hdr_wr_i = 1'b0;
      pld_wr_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic push_hdr(logic [31:0] w);
      hdr_wr_i = 1'b1; hdr_wdata_i = w;
      @(negedge clk);
      hdr_wr_i = 1'b0;
   endtask

   task automatic push_pld(logic [31:0] w);
      pld_wr_i = 1'b1; pld_wdata_i = w;
      @(negedge clk);
      pld_wr_i = 1'b0;
   endtask

   task automatic wait_done();
      repeat (3) @(negedge clk);
      while (!(hdr_empty_o && pld_empty_o)) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      int base;
      do_reset();
      // R9: reset state
      chk("R9 hdr_empty", hdr_empty_o, 1);
      chk("R9 pld_empty", pld_empty_o, 1);
      chk("R9 full flags", {hdr_full_o, pld_full_o}, 0);
      chk("R9 ovf flags", {hdr_ovf_o, pld_ovf_o}, 0);
      chk("R9 tx_valid", tx_valid_o, 0);

      // R1 R2 R3 R4 R5: table of packets
      for (int v = 0; v < NVEC; v++) begin
         int nw;
         base = ncap;
         nw = VEC_HDR[v][3] ? (int'(VEC_HDR[v][23:8]) + 3) / 4 : 0;
         for (int k = 0; k < nw; k++) push_pld(pword(v, k));
         push_hdr(VEC_HDR[v]);
         wait_done();
         add_exp(VEC_HDR[v], v);
         cmp_stream($sformatf("R1/R2/R3/R4/R5 vector %0d", v), base);
      end

      // R10: back-to-back headers kept in order, with padding discarded (R4)
      base = ncap;
      push_pld(pword(4, 0));
      push_pld(pword(5, 0));
      push_pld(pword(5, 1));
      push_hdr(VEC_HDR[4]);
      push_hdr(VEC_HDR[0]);
      push_hdr(VEC_HDR[5]);
      wait_done();
      add_exp(VEC_HDR[4], 4);
      add_exp(VEC_HDR[0], 0);
      add_exp(VEC_HDR[5], 5);
      cmp_stream("R10 ordered stream", base);

      // R6: stall while payload missing
      base = ncap;
      push_hdr(32'h0000_0639);
      repeat (12) @(negedge clk);
      chk("R6 stalled tx_valid", tx_valid_o, 0);
      chk("R6 bytes before stall", ncap - base, 4);
      chk("R8 busy hides hdr_empty", hdr_empty_o, 0);
      push_pld(pword(2, 0));
      repeat (10) @(negedge clk);
      chk("R6 still stalled after partial payload", ncap - base, 8);
      push_pld(pword(2, 1));
      wait_done();
      add_exp(32'h0000_0639, 2);
      cmp_stream("R6 resumed stream", base);

      // R7: payload queue overflow
      do_reset();
      for (int k = 0; k < 16; k++) push_pld(pword(7, k));
      chk("R7 pld_full at depth", pld_full_o, 1);
      chk("R7 pld_ovf clear before drop", pld_ovf_o, 0);
      push_pld(32'hDEAD_BEEF);
      chk("R7 pld_ovf set", pld_ovf_o, 1);
      base = ncap;
      push_hdr(32'h0000_4039);
      wait_done();
      add_exp(32'h0000_4039, 7);
      cmp_stream("R7 dropped payload word absent", base);
      chk("R7 pld_ovf sticky", pld_ovf_o, 1);

      // R7: header queue overflow behind a starved long packet
      do_reset();
      base = ncap;
      push_hdr(32'h0000_0839);
      repeat (8) @(negedge clk);
      for (int k = 0; k < 16; k++) push_hdr(32'h0000_0005 | (32'(k) << 8));
      chk("R7 hdr_full at depth", hdr_full_o, 1);
      push_hdr(32'h00AB_CD05);
      chk("R7 hdr_ovf set", hdr_ovf_o, 1);
      push_pld(pword(1, 0));
      push_pld(pword(1, 1));
      wait_done();
      add_exp(32'h0000_0839, 1);
      for (int k = 0; k < 16; k++) add_exp(32'h0000_0005 | (32'(k) << 8), 0);
      cmp_stream("R7 dropped header absent", base);
      chk("R8 both empty after drain", {hdr_empty_o, pld_empty_o}, 2'b11);
      chk("R7 hdr_ovf sticky", hdr_ovf_o, 1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule